// File: doc/BRIEF.md
# Banked Register Invert and Compare-Skip Execute Unit

This unit executes two single-word register-file instructions of an 8-bit accumulator machine. The first instruction replaces a data-memory byte with its bitwise inverse. The result goes either back to the byte or into the working register W, and the N and Z flags are updated. The second instruction compares a data-memory byte with W by unsigned subtraction. When the two are equal, it tells the fetch stage how many prefetched words to discard: one word, or two when the following instruction occupies two words. The compare writes nothing.

Each instruction takes one instruction cycle, which is four clock periods. The instruction word and the bank-select value are captured on the first phase. The byte is read on the second phase, the result is formed on the third, and the destination is written on the fourth. A 12-bit data-memory address is built from a 4-bit bank and the 8-bit file field. A per-instruction bit chooses the bank: it comes either from the bank-select input or from a fixed access map. The access map sends the low half of the file range to bank 0 and the high half to the top bank. The data memory is outside the unit: the unit drives its address and write strobe, and the memory returns read data combinationally. Any instruction word outside the two encodings passes through four phases with no effect.

Top module: `cs_regop_unit`

## Requirements
- R1: While reset is asserted and directly after it is released, phase_o is 0, w_o is 0x00, flag_n_o and flag_z_o are 0, mem_we_o is 0 and squash_o is 0.
- R2: phase_o counts 0,1,2,3,0,... one step per clock. The instruction word and bank-select value are captured at the clock edge that ends phase 0.
- R3: The invert instruction is bits[15:10]=000111, with d in bit 9, a in bit 8 and the file field in bits[7:0]. With d=1 it writes the inverse of the byte back to the same address during phase 3 and leaves W unchanged. For example, 0x13 becomes 0xEC.
- R4: The invert instruction with d=0 loads the inverse of the byte into W at the end of phase 3 and performs no memory write.
- R5: After an invert instruction, flag_n_o equals bit 7 of the result and flag_z_o is 1 exactly when the result is 0x00. Neither flag, nor W, changes at any other edge than the one ending phase 3.
- R6: With a=1, the address driven in phases 1 to 3 is {bank-select[3:0], file[7:0]}. It is held stable across those phases.
- R7: With a=0, the bank-select input is ignored. File values 0x00–0x7F address bank 0, and file values 0x80–0xFF address bank 15.
- R8: The compare instruction is bits[15:9]=0110001, with a in bit 8 and the file field in bits[7:0]. It performs no memory write and leaves W, N and Z unchanged.
- R9: During phase 3 of a compare whose byte equals W, squash_o is 2 when next_two_word_i is 1 and 1 otherwise. When the byte differs from W, and in every other phase or instruction, squash_o is 0. The value 3 never appears.
- R10: Any instruction word matching neither encoding leaves memory, W, N and Z unchanged and produces squash_o = 0.
- R11: mem_we_o is asserted only in phase 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 16 | Instruction word, sampled at the end of phase 0 |
| bsr_i | input | 4 | Bank-select value, sampled at the end of phase 0 |
| next_two_word_i | input | 1 | Following instruction is two words long, looked at in phase 3 |
| mem_addr_o | output | 12 | Data-memory address |
| mem_rdata_i | input | 8 | Data-memory read data, combinational from mem_addr_o |
| mem_we_o | output | 1 | Data-memory write strobe, write at the clock edge |
| mem_wdata_o | output | 8 | Data-memory write data |
| w_o | output | 8 | Working register W |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| squash_o | output | 2 | Number of prefetched words to discard (0, 1 or 2) |
| phase_o | output | 2 | Current phase 0..3 |

## Verification
The assertions take four things about the environment for granted:
- instr_i and bsr_i are settled before the clock edge that ends phase 0;
- next_two_word_i is valid throughout phase 3;
- the memory returns read data for mem_addr_o within the same period;
- a write takes effect at the edge where mem_we_o is high.

The bench respects all four. It changes inputs only on the falling edge, aligned to phase 0, and keeps each value for a full instruction cycle. It models the memory as a combinational-read, edge-written array. It sweeps every file address under both bank modes and both destinations, compare cases with and without equality and with both following-instruction lengths, and every value of the seven opcode bits.

// File: rtl/cs_pkg.sv
package cs_pkg;
   typedef enum logic [1:0] {
      PH_Q1 = 2'd0,
      PH_Q2 = 2'd1,
      PH_Q3 = 2'd2,
      PH_Q4 = 2'd3
   } phase_e;

   typedef enum logic [1:0] {
      OP_NONE    = 2'd0,
      OP_INVERT  = 2'd1,
      OP_CMPSKIP = 2'd2
   } op_e;

   localparam logic [5:0] OPC_INVERT  = 6'b000111;
   localparam logic [6:0] OPC_CMPSKIP = 7'b0110001;
endpackage

// File: rtl/cs_phase_seq.sv
module cs_phase_seq
   import cs_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   output phase_e phase_o
);
   logic [1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= 2'd0;
      else        cnt_q <= cnt_q + 2'd1;
   end

   assign phase_o = phase_e'(cnt_q);
endmodule

// File: rtl/cs_decode.sv
module cs_decode
   import cs_pkg::*;
#(
   parameter int INSTR_W = 16,
   parameter int FILE_W  = 8
) (
   input  logic [INSTR_W-1:0] instr_i,
   output op_e                op_o,
   output logic               to_file_o,
   output logic               banked_o,
   output logic [FILE_W-1:0]  faddr_o
);
   localparam int DEST_BIT = FILE_W + 1;
   localparam int BANK_BIT = FILE_W;

   always_comb begin
      if (instr_i[INSTR_W-1 -: 6] == OPC_INVERT)
         op_o = OP_INVERT;
      else if (instr_i[INSTR_W-1 -: 7] == OPC_CMPSKIP)
         op_o = OP_CMPSKIP;
      else
         op_o = OP_NONE;
   end

   assign to_file_o = instr_i[DEST_BIT];
   assign banked_o  = instr_i[BANK_BIT];
   assign faddr_o   = instr_i[FILE_W-1:0];
endmodule

// File: rtl/cs_bank_addr.sv
module cs_bank_addr #(
   parameter int FILE_W       = 8,
   parameter int BANK_W       = 4,
   parameter bit SPLIT_ACCESS = 1'b1,
   localparam int ADDR_W      = BANK_W + FILE_W
) (
   input  logic              banked_i,
   input  logic [BANK_W-1:0] bsr_i,
   input  logic [FILE_W-1:0] faddr_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic [BANK_W-1:0] access_bank;

   generate
      if (SPLIT_ACCESS) begin : g_split
         assign access_bank = faddr_i[FILE_W-1] ? {BANK_W{1'b1}} : {BANK_W{1'b0}};
      end else begin : g_low_only
         assign access_bank = {BANK_W{1'b0}};
      end
   endgenerate

   assign addr_o = {(banked_i ? bsr_i : access_bank), faddr_i};
endmodule

// File: rtl/cs_regop_unit.sv
module cs_regop_unit
   import cs_pkg::*;
#(
   parameter int INSTR_W      = 16,
   parameter int DATA_W       = 8,
   parameter int FILE_W       = 8,
   parameter int BANK_W       = 4,
   parameter bit SPLIT_ACCESS = 1'b1,
   localparam int ADDR_W      = BANK_W + FILE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INSTR_W-1:0] instr_i,
   input  logic [BANK_W-1:0] bsr_i,
   input  logic              next_two_word_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              mem_we_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic [DATA_W-1:0] w_o,
   output logic              flag_n_o,
   output logic              flag_z_o,
   output logic [1:0]        squash_o,
   output logic [1:0]        phase_o
);
   generate
      if (INSTR_W != 16) begin : g_bad_instr_w
         $error("cs_regop_unit: INSTR_W must be 16");
      end
      if (FILE_W != 8) begin : g_bad_file_w
         $error("cs_regop_unit: FILE_W must be 8");
      end
      if (DATA_W < 2) begin : g_bad_data_w
         $error("cs_regop_unit: DATA_W must be at least 2");
      end
      if (BANK_W < 1) begin : g_bad_bank_w
         $error("cs_regop_unit: BANK_W must be at least 1");
      end
   endgenerate

   phase_e              phase;
   op_e                 dec_op;
   logic                dec_to_file;
   logic                dec_banked;
   logic [FILE_W-1:0]   dec_faddr;

   op_e                 op_q;
   logic                to_file_q;
   logic                banked_q;
   logic [FILE_W-1:0]   faddr_q;
   logic [BANK_W-1:0]   bank_q;
   logic [DATA_W-1:0]   data_q;
   logic [DATA_W-1:0]   res_q;
   logic                eq_q;
   logic [DATA_W-1:0]   w_q;
   logic                n_q;
   logic                z_q;
   logic [DATA_W-1:0]   diff;

   cs_phase_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase_o (phase)
   );

   cs_decode #(
      .INSTR_W (INSTR_W),
      .FILE_W  (FILE_W)
   ) u_dec (
      .instr_i   (instr_i),
      .op_o      (dec_op),
      .to_file_o (dec_to_file),
      .banked_o  (dec_banked),
      .faddr_o   (dec_faddr)
   );

   cs_bank_addr #(
      .FILE_W       (FILE_W),
      .BANK_W       (BANK_W),
      .SPLIT_ACCESS (SPLIT_ACCESS)
   ) u_addr (
      .banked_i (banked_q),
      .bsr_i    (bank_q),
      .faddr_i  (faddr_q),
      .addr_o   (mem_addr_o)
   );

   assign diff = data_q - w_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q      <= OP_NONE;
         to_file_q <= 1'b0;
         banked_q  <= 1'b0;
         faddr_q   <= '0;
         bank_q    <= '0;
         data_q    <= '0;
         res_q     <= '0;
         eq_q      <= 1'b0;
         w_q       <= '0;
         n_q       <= 1'b0;
         z_q       <= 1'b0;
      end else begin
         case (phase)
            PH_Q1: begin
               op_q      <= dec_op;
               to_file_q <= dec_to_file;
               banked_q  <= dec_banked;
               faddr_q   <= dec_faddr;
               bank_q    <= bsr_i;
            end
            PH_Q2: data_q <= mem_rdata_i;
            PH_Q3: begin
               res_q <= ~data_q;
               eq_q  <= (diff == '0);
            end
            PH_Q4: begin
               if (op_q == OP_INVERT) begin
                  n_q <= res_q[DATA_W-1];
                  z_q <= (res_q == '0);
                  if (!to_file_q) w_q <= res_q;
               end
            end
            default: ;
         endcase
      end
   end

   assign mem_we_o    = (phase == PH_Q4) && (op_q == OP_INVERT) && to_file_q;
   assign mem_wdata_o = res_q;
   assign squash_o    = ((phase == PH_Q4) && (op_q == OP_CMPSKIP) && eq_q)
                        ? (next_two_word_i ? 2'd2 : 2'd1) : 2'd0;
   assign w_o         = w_q;
   assign flag_n_o    = n_q;
   assign flag_z_o    = z_q;
   assign phase_o     = phase;
endmodule

// File: rtl/cs_regop_unit_chk.sv
module cs_regop_unit_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        phase_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              mem_we_o,
   input logic [DATA_W-1:0] w_o,
   input logic              flag_n_o,
   input logic              flag_z_o,
   input logic [1:0]        squash_o
);
   assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> phase_o == $past(phase_o) + 2'd1);

   assert_write_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> phase_o == 2'd3);

   assert_write_keeps_w_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |=> $stable(w_o));

   assert_w_only_end_q4_R5: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o != 2'd3 |=> $stable(w_o));

   assert_flags_only_end_q4_R5: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o != 2'd3 |=> $stable({flag_n_o, flag_z_o}));

   assert_addr_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == 2'd1 || phase_o == 2'd2) |=> $stable(mem_addr_o));

   assert_squash_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
      squash_o != 2'd0 |-> phase_o == 2'd3);

   assert_squash_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      squash_o != 2'd3);

   assert_compare_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we_o && squash_o != 2'd0));
endmodule

bind cs_regop_unit cs_regop_unit_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) chk_i (.*);

// File: tb/cs_regop_unit_tb_top.sv
module cs_regop_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] instr_i = 16'h0000;
   logic [3:0]  bsr_i = 4'h0;
   logic        next_two_word_i = 1'b0;
   logic [11:0] mem_addr_o;
   logic [7:0]  mem_rdata_i;
   logic        mem_we_o;
   logic [7:0]  mem_wdata_o;
   logic [7:0]  w_o;
   logic        flag_n_o;
   logic        flag_z_o;
   logic [1:0]  squash_o;
   logic [1:0]  phase_o;

   logic [7:0]  mem [4096];

   int   n_checks = 0;
   int   n_errors = 0;
   bit   done = 1'b0;

   logic [7:0] w_m = 8'h00;
   logic       n_m = 1'b0;
   logic       z_m = 1'b0;

   always #5 clk = ~clk;

   cs_regop_unit dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .instr_i         (instr_i),
      .bsr_i           (bsr_i),
      .next_two_word_i (next_two_word_i),
      .mem_addr_o      (mem_addr_o),
      .mem_rdata_i     (mem_rdata_i),
      .mem_we_o        (mem_we_o),
      .mem_wdata_o     (mem_wdata_o),
      .w_o             (w_o),
      .flag_n_o        (flag_n_o),
      .flag_z_o        (flag_z_o),
      .squash_o        (squash_o),
      .phase_o         (phase_o)
   );

   assign mem_rdata_i = mem[mem_addr_o];
   always @(posedge clk) if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp_v);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp_v);
      end
   endtask

   task automatic run_instr(input logic [15:0] ins, input logic [3:0] bsr,
                            input bit two);
      bit          is_inv;
      bit          is_cmp;
      logic [11:0] addr;
      logic [7:0]  old;
      logic [7:0]  res;
      logic [1:0]  exp_sq;
      bit          exp_we;
      is_inv = (ins[15:10] == 6'b000111);
      is_cmp = (ins[15:9] == 7'b0110001);
      addr   = ins[8] ? {bsr, ins[7:0]} : {(ins[7] ? 4'hF : 4'h0), ins[7:0]};
      old    = mem[addr];
      res    = ~old;
      exp_we = is_inv && ins[9];
      exp_sq = (is_cmp && old == w_m) ? (two ? 2'd2 : 2'd1) : 2'd0;
      // phase 0
      check(phase_o == 2'd0, "R2", 32'(phase_o), 0);
      instr_i = ins; bsr_i = bsr; next_two_word_i = two;
      @(posedge clk); @(negedge clk);
      check(phase_o == 2'd1, "R2", 32'(phase_o), 1);
      check(mem_we_o == 1'b0, "R11", 32'(mem_we_o), 0);
      if (is_inv || is_cmp)
         check(mem_addr_o == addr, ins[8] ? "R6" : "R7", 32'(mem_addr_o), 32'(addr));
      @(posedge clk); @(negedge clk);
      check(mem_we_o == 1'b0 && squash_o == 2'd0, "R11", 32'({mem_we_o, squash_o}), 0);
      @(posedge clk); @(negedge clk);
      check(phase_o == 2'd3, "R2", 32'(phase_o), 3);
      check(squash_o == exp_sq, is_cmp ? "R9" : "R10", 32'(squash_o), 32'(exp_sq));
      check(mem_we_o == exp_we, is_inv ? "R3" : (is_cmp ? "R8" : "R10"),
            32'(mem_we_o), 32'(exp_we));
      if (exp_we) begin
         check(mem_addr_o == addr, "R3", 32'(mem_addr_o), 32'(addr));
         check(mem_wdata_o == res, "R3", 32'(mem_wdata_o), 32'(res));
      end
      @(posedge clk); @(negedge clk);
      if (is_inv) begin
         n_m = res[7];
         z_m = (res == 8'h00);
         if (!ins[9]) w_m = res;
      end
      check(w_o == w_m, is_inv ? (ins[9] ? "R3" : "R4") : (is_cmp ? "R8" : "R10"),
            32'(w_o), 32'(w_m));
      check(flag_n_o == n_m && flag_z_o == z_m, is_inv ? "R5" : (is_cmp ? "R8" : "R10"),
            32'({flag_n_o, flag_z_o}), 32'({n_m, z_m}));
      check(mem[addr] == (exp_we ? res : old), exp_we ? "R3" : "R10",
            32'(mem[addr]), 32'(exp_we ? res : old));
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 29) + (i >> 5));
      repeat (3) @(negedge clk);
      check(phase_o == 2'd0 && mem_we_o == 1'b0 && squash_o == 2'd0, "R1",
            32'({phase_o, mem_we_o, squash_o}), 0);
      rst_n = 1'b1;
      check(w_o == 8'h00 && flag_n_o == 1'b0 && flag_z_o == 1'b0, "R1",
            32'({w_o, flag_n_o, flag_z_o}), 0);
      check(phase_o == 2'd0, "R1", 32'(phase_o), 0);

      // R3: documented value 0x13 becomes 0xEC in place
      mem[12'h213] = 8'h13;
      run_instr({6'b000111, 1'b1, 1'b1, 8'h13}, 4'h2, 1'b0);
      check(mem[12'h213] == 8'hEC, "R3", 32'(mem[12'h213]), 32'hEC);
      // R5: result zero sets Z, to W
      mem[12'h005] = 8'hFF;
      run_instr({6'b000111, 1'b0, 1'b0, 8'h05}, 4'h9, 1'b0);
      check(flag_z_o == 1'b1 && w_o == 8'h00, "R5", 32'({w_o, flag_z_o}), 1);

      // R3 R4 R5 R6 R7: all file addresses, both bank modes, both destinations
      for (int f = 0; f < 256; f++)
         for (int m = 0; m < 4; m++)
            run_instr({6'b000111, m[1], m[0], f[7:0]}, 4'(f) ^ 4'h5, 1'b0);

      // R8 R9: compares with equal and unequal bytes, both following lengths
      for (int k = 0; k < 64; k++) begin
         logic [11:0] tgt;
         tgt = {4'(k), 8'(k * 4)};
         if (k[0] == 1'b0) mem[tgt] = w_m;
         else              mem[tgt] = w_m + 8'(k);
         run_instr({7'b0110001, 1'b1, 8'(k * 4)}, 4'(k), k[1]);
         // swap W for the next round through an invert into W
         run_instr({6'b000111, 1'b0, 1'b1, 8'(k * 3)}, 4'(k + 7), 1'b0);
      end
      // R7 R9: access-bank compare at high file addresses, bsr ignored
      mem[12'hF90] = w_m;
      run_instr({7'b0110001, 1'b0, 8'h90}, 4'h3, 1'b1);

      // R10: every value of the seven opcode bits
      for (int o = 0; o < 128; o++)
         run_instr({7'(o), 1'b1, 8'(o * 5 + 1)}, 4'(o), o[0]);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end
endmodule